// File: doc/BRIEF.md
# Floating-Point Compare Condition Encoder

This unit compares two IEEE-754 double-precision operands given as raw bit patterns and returns a four-bit one-hot condition nibble. The nibble reports whether the first operand is less than, greater than or equal to the second, or whether the pair is unordered. It does no arithmetic and no rounding. Ordering comes straight from the sign, exponent and fraction fields. Each compare also writes the nibble into a status copy that persists, and it updates three exception flags that keep their values until reset.

Two compare variants are provided, selected per strobe. The quiet variant records an unordered outcome by setting the invalid summary flag and the signalling-operand flag. It leaves the flags untouched when the outcome is ordered. The ordered variant first clears the invalid summary flag. It then sets that flag, together with the invalid-compare flag, only if the outcome is unordered. A parameter chooses whether the operands are registered on entry, which trades one cycle of latency for a shorter path into the compare.

Top module: `fcmp_cc_unit`

## Requirements
- R1: Every result nibble is one-hot: 4'b1000 means less than, 4'b0100 greater than, 4'b0010 equal and 4'b0001 unordered (bit 3 down to bit 0).
- R2: An operand is NaN when its 11-bit exponent (bits 62:52) is all ones and its 52-bit fraction is non-zero. Any NaN operand gives 4'b0001. Infinities are ordered values: +inf is greater than every finite value, and -inf is less than every finite value.
- R3: Positive zero and negative zero compare as equal (4'b0010).
- R4: Non-NaN operands are ordered by sign and then magnitude. A negative operand is less than a non-negative one unless both are zeros. When both operands are negative, the larger magnitude is the lesser value.
- R5: With IN_REG=1, res_valid is high in exactly the one cycle that is two clock edges after an accepted in_valid strobe. With IN_REG=0 it is one edge after. res_valid is low at every other time.
- R6: stat_cc takes the result nibble at the moment res_valid rises. It holds that value until the next result.
- R7: Quiet variant (in_var=0): an unordered result sets stat_inv_sum and stat_inv_snan. An ordered result leaves all three flags unchanged.
- R8: Ordered variant (in_var=1): stat_inv_sum becomes 1 on an unordered result and 0 on an ordered one. An unordered result also sets stat_inv_cmp. stat_inv_snan is left unchanged.
- R9: stat_inv_snan and stat_inv_cmp, once set, stay set until reset.
- R10: While and after reset, res_valid, res_cc, stat_cc and all three flags are zero.
- R11: In cycles with no result, stat_cc and the three flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe, one compare per high cycle |
| in_var | input | 1 | Variant: 0 quiet, 1 ordered |
| op_a | input | 64 | First operand bit pattern |
| op_b | input | 64 | Second operand bit pattern |
| res_valid | output | 1 | Result nibble is valid this cycle |
| res_cc | output | 4 | One-hot condition nibble |
| stat_cc | output | 4 | Persistent copy of the latest nibble |
| stat_inv_sum | output | 1 | Invalid-operation summary flag |
| stat_inv_snan | output | 1 | Signalling-operand invalid flag (sticky) |
| stat_inv_cmp | output | 1 | Invalid-compare flag (sticky) |

## Verification
With the default input register, a strobe applied in one cycle produces res_valid, the nibble and the status update together, two rising edges later. All four appear at the same edge, because the status register and the result register load in parallel. Each strobe is driven at a falling edge, and its expected item is queued at that moment. The monitor samples at every falling edge and pops an item only when res_valid is high, so a result that comes early, late or more than once is reported as a miscompare. In cycles with no result, the monitor compares the status outputs against the last item it popped.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CC_W  = 4;
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;

  typedef enum logic {
    VAR_QUIET   = 1'b0,
    VAR_ORDERED = 1'b1
  } cmp_var_e;

  typedef struct packed {
    logic inv_sum;
    logic inv_snan;
    logic inv_cmp;
  } flag_t;

  function automatic logic [CC_W-1:0] cc_code(input int pos);
    logic [CC_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]   op,
  output logic           is_nan,
  output logic           is_zero,
  output logic           sign,
  output logic [W-2:0]   mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    sign    = op[W-1];
    mag     = op[W-2:0];
    exp_f   = op[W-2:FRAC_W];
    frac_f  = op[FRAC_W-1:0];
    is_nan  = (&exp_f) && (|frac_f);
    is_zero = ~(|mag);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             a_nan,
  input  logic             b_nan,
  input  logic             a_zero,
  input  logic             b_zero,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output logic [CC_W-1:0]  cc
);
  logic mag_lt;
  logic mag_eq;

  always_comb begin
    mag_lt = (a_mag < b_mag);
    mag_eq = (a_mag == b_mag);
    if (a_nan || b_nan)
      cc = cc_code(CC_UN);
    else if ((a_zero && b_zero) || ((a_sign == b_sign) && mag_eq))
      cc = cc_code(CC_EQ);
    else if (a_sign != b_sign)
      cc = a_sign ? cc_code(CC_LT) : cc_code(CC_GT);
    else if (!a_sign)
      cc = mag_lt ? cc_code(CC_LT) : cc_code(CC_GT);
    else
      cc = mag_lt ? cc_code(CC_GT) : cc_code(CC_LT);
  end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  cmp_var_e        var_sel,
  input  logic [CC_W-1:0] cc,
  output logic [CC_W-1:0] stat_cc,
  output flag_t           flags
);
  logic  unord;
  flag_t flags_nxt;

  always_comb begin
    unord     = cc[CC_UN];
    flags_nxt = flags;
    if (var_sel == VAR_ORDERED) begin
      flags_nxt.inv_sum = unord;
      if (unord) flags_nxt.inv_cmp = 1'b1;
    end else if (unord) begin
      flags_nxt.inv_sum  = 1'b1;
      flags_nxt.inv_snan = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_cc <= '0;
      flags   <= '0;
    end else if (upd) begin
      stat_cc <= cc;
      flags   <= flags_nxt;
    end
  end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter bit IN_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_var,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic                    res_valid,
  output logic [3:0]              res_cc,
  output logic [3:0]              stat_cc,
  output logic                    stat_inv_sum,
  output logic                    stat_inv_snan,
  output logic                    stat_inv_cmp
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = W - 1;

  logic         s_valid;
  cmp_var_e     s_var;
  logic [W-1:0] s_ops [2];

  generate
    if (IN_REG) begin : g_inreg
      always_ff @(posedge clk) begin
        if (rst) begin
          s_valid  <= 1'b0;
          s_var    <= VAR_QUIET;
          s_ops[0] <= '0;
          s_ops[1] <= '0;
        end else begin
          s_valid <= in_valid;
          if (in_valid) begin
            s_var    <= cmp_var_e'(in_var);
            s_ops[0] <= op_a;
            s_ops[1] <= op_b;
          end
        end
      end
    end else begin : g_direct
      always_comb begin
        s_valid  = in_valid;
        s_var    = cmp_var_e'(in_var);
        s_ops[0] = op_a;
        s_ops[1] = op_b;
      end
    end
  endgenerate

  logic             c_nan  [2];
  logic             c_zero [2];
  logic             c_sign [2];
  logic [MAG_W-1:0] c_mag  [2];

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cls
      fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op      (s_ops[i]),
        .is_nan  (c_nan[i]),
        .is_zero (c_zero[i]),
        .sign    (c_sign[i]),
        .mag     (c_mag[i])
      );
    end
  endgenerate

  logic [CC_W-1:0] cc_comb;

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .a_nan  (c_nan[0]),
    .b_nan  (c_nan[1]),
    .a_zero (c_zero[0]),
    .b_zero (c_zero[1]),
    .a_sign (c_sign[0]),
    .b_sign (c_sign[1]),
    .a_mag  (c_mag[0]),
    .b_mag  (c_mag[1]),
    .cc     (cc_comb)
  );

  flag_t flags_q;

  fcmp_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .upd     (s_valid),
    .var_sel (s_var),
    .cc      (cc_comb),
    .stat_cc (stat_cc),
    .flags   (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_cc    <= '0;
    end else begin
      res_valid <= s_valid;
      if (s_valid) res_cc <= cc_comb;
    end
  end

  always_comb begin
    stat_inv_sum  = flags_q.inv_sum;
    stat_inv_snan = flags_q.inv_snan;
    stat_inv_cmp  = flags_q.inv_cmp;
  end
endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker #(
  parameter bit IN_REG = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_var,
  input logic       res_valid,
  input logic [3:0] res_cc,
  input logic [3:0] stat_cc,
  input logic       stat_inv_sum,
  input logic       stat_inv_snan,
  input logic       stat_inv_cmp
);
  logic v1, v2, m1, m2;
  logic exp_valid, exp_var;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; m1 <= 1'b0; m2 <= 1'b0;
    end else begin
      v1 <= in_valid; v2 <= v1;
      m1 <= in_var;   m2 <= m1;
    end
  end

  assign exp_valid = IN_REG ? v2 : v1;
  assign exp_var   = IN_REG ? m2 : m1;

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones(res_cc) == 1)); // R1
  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (rst)
    res_valid == exp_valid); // R5
  AST_STAT_FIELD: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (stat_cc == res_cc)); // R6
  AST_UNORD_SUM: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_cc[0]) |-> stat_inv_sum); // R7
  AST_ORD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (res_valid && exp_var && !res_cc[0]) |-> !stat_inv_sum); // R8
  AST_SNAN_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_inv_snan |=> stat_inv_snan); // R9
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_inv_cmp |=> stat_inv_cmp); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> (res_valid || ($stable(stat_cc) && $stable(stat_inv_snan)))); // R11
endmodule

bind fcmp_cc_unit fcmp_cc_checker #(.IN_REG(IN_REG)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_var        (in_var),
  .res_valid     (res_valid),
  .res_cc        (res_cc),
  .stat_cc       (stat_cc),
  .stat_inv_sum  (stat_inv_sum),
  .stat_inv_snan (stat_inv_snan),
  .stat_inv_cmp  (stat_inv_cmp)
);

// File: tb/fcmp_cc_unit_bench.sv
module fcmp_cc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_var = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic [3:0]  res_cc;
  logic [3:0]  stat_cc;
  logic        stat_inv_sum, stat_inv_snan, stat_inv_cmp;

  always #4 clk = ~clk;

  fcmp_cc_unit u_fcmp_cc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_var(in_var),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_cc(res_cc),
    .stat_cc(stat_cc), .stat_inv_sum(stat_inv_sum),
    .stat_inv_snan(stat_inv_snan), .stat_inv_cmp(stat_inv_cmp)
  );

  typedef struct {
    logic [3:0] cc;
    logic       sum, snan, cmpf;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_chk = 0;
  int   n_bad = 0;
  logic m_sum = 0, m_snan = 0, m_cmp = 0;
  bit   done = 0;

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic v, input string tag);
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; in_var = v; in_valid = 1'b1;
    e.cc = ref_cc(a, b);
    if (v) begin
      m_sum = e.cc[0];
      if (e.cc[0]) m_cmp = 1'b1;
    end else if (e.cc[0]) begin
      m_sum = 1'b1; m_snan = 1'b1;
    end
    e.sum = m_sum; e.snan = m_snan; e.cmpf = m_cmp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: scoreboard pop on every result, hold check otherwise
  initial begin
    last.cc = 0; last.sum = 0; last.snan = 0; last.cmpf = 0; last.tag = "R10";
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (res_valid) begin
          if (q.size() == 0) begin
            check("R5 unexpected result", 32'(res_valid), 32'd0);
          end else begin
            last = q.pop_front();
            check({last.tag, " cc"}, 32'(res_cc), 32'(last.cc));
            check("R6 stat_cc", 32'(stat_cc), 32'(last.cc));
            check({last.tag, " flags"}, {29'd0, stat_inv_sum, stat_inv_snan, stat_inv_cmp},
                  {29'd0, last.sum, last.snan, last.cmpf});
          end
        end else begin
          check("R11 hold", {25'd0, stat_cc, stat_inv_sum, stat_inv_snan, stat_inv_cmp},
                {25'd0, last.cc, last.sum, last.snan, last.cmpf});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
  localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
  localparam logic [63:0] P5 = 64'h4014000000000000, N3 = 64'hC008000000000000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000, NINF = 64'hFFF0000000000000;
  localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF, NMAX = 64'hFFEFFFFFFFFFFFFF;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000, SNAN = 64'h7FF0000000000001;

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 reset", {24'd0, res_valid, res_cc, stat_cc, stat_inv_sum, stat_inv_snan, stat_inv_cmp},
          32'd0);
    rst = 1'b0;
    idle(2);
    apply(P1, P2, 0, "R1 less");
    apply(P2, P1, 0, "R1 greater");
    apply(P5, P5, 0, "R1 equal");
    idle(3);
    apply(PZ, NZ, 0, "R3 zeros");
    apply(NZ, PZ, 1, "R3 zeros ord");
    apply(N1, N2, 0, "R4 neg greater");
    apply(N2, N1, 0, "R4 neg less");
    apply(N3, P5, 0, "R4 mixed sign");
    apply(P5, N3, 1, "R4 mixed sign b");
    apply(NZ, N1, 0, "R4 negzero vs neg");
    idle(2);
    apply(PINF, PMAX, 0, "R2 inf gt");
    apply(NINF, NMAX, 0, "R2 neg inf lt");
    apply(PINF, PINF, 0, "R2 inf eq");
    apply(P1, P1, 1, "R8 ordered ok");
    idle(2);
    apply(QNAN, P1, 0, "R7 quiet nan");
    idle(2);
    apply(P1, P2, 0, "R7 quiet ordered keeps");
    apply(P1, SNAN, 1, "R8 ordered nan");
    apply(P2, P1, 1, "R8 ordered clears sum");
    apply(QNAN, QNAN, 1, "R8 both nan");
    apply(N1, P1, 1, "R9 sticky");
    idle(4);
    apply(NINF, QNAN, 0, "R2 nan vs inf");
    idle(6);
    check("R5 queue drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule